// File: doc/BRIEF.md
# Command Packet Register Front End

This block sits between a host processor's register bus and the packet transmitter of a serial display link. Software stages the payload of a command packet word by word through a shared data register, then writes the packet header. Writing the header is what releases the packet to the link. The block holds three queues: one for headers, one for outgoing payload words, and one for returned read data.

On the link side, a valid/ready port sends the header first. For a long packet, the header is followed by as many payload words as its word count calls for. Bytes returned by the display are packed four to a word with byte 0 in the low bits, and a partial last word is padded with zeros. Software reads these words back through the same shared data register.

A status register reports, for each queue, whether it is empty or full. It also carries a busy flag that covers a read transaction, plus sticky overflow and underflow indications. Software knows a packet has gone out when both the header queue and the payload queue read as empty.

Top module: `cmd_pkt_front`

## Requirements
- R1: A register write to address 0x6C pushes the 32-bit data word into the header queue. Status bit 0 (header queue empty) is cleared in the cycle after the push.
- R2: A header with data-type bit 3 set (header bits 5:0 hold the data type) is a long packet. It is followed on the link port by ceil(WC/4) payload words, where WC is header bits 23:8. A header with data-type bit 3 clear is sent alone.
- R3: Payload words written to address 0x70 are never presented on the link port until a header has been written that claims them.
- R4: The status register at address 0x74 holds these bits: 0 header empty, 1 header full, 2 payload empty, 3 payload full, 4 read-data empty, 5 read-data full, 6 read busy, 7 overflow, 8 underflow. All other bits read zero.
- R5: Each queue holds 16 words and reports full at 16. A write into a full queue is dropped and sets sticky bit 7.
- R6: A register read of address 0x70 returns and removes the oldest read-data word. A read while that queue is empty returns zero and sets sticky bit 8.
- R7: Returned bytes are packed little-endian, with the first byte in bits 7:0. A word is stored after four bytes, or at the byte marked last, and its unused upper bytes are zero.
- R8: Writing a read-request header sets the busy bit in the next cycle. A read-request header has data-type bit 3 clear and bits 2:0 equal to 100 or 110. Busy clears in the cycle after the last returned byte is accepted.
- R9: While the link port shows valid without ready, valid and the word stay unchanged.
- R10: After reset the status register reads 0x15 and the link port is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (pops read data at 0x70) |
| regAddr | input | 8 | Register byte address |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational on address) |
| pktValid | output | 1 | Link word valid |
| pktReady | input | 1 | Link accepts word |
| pktData | output | 32 | Header or payload word |
| pktIsHeader | output | 1 | Current link word is a header |
| rxValid | input | 1 | Returned byte valid |
| rxByte | input | 8 | Returned byte |
| rxLast | input | 1 | Final byte of a read response |

## Verification
The hardest conditions to reach are the full queues, because the header queue drains onto the link as fast as it fills. The stimulus holds pktReady low while it writes seventeen headers. That fills the queue and makes the seventeenth write overflow. Only afterwards does it release the link and count what comes out. The read-data queue is filled by streaming seventeen four-byte responses with no register reads in between. The word that arrives in the overfull queue must never appear among the sixteen words popped afterwards.

// File: rtl/cmdfe_pkg.sv
package cmdfe_pkg;
  localparam logic [7:0] ADDR_HDR  = 8'h6C;
  localparam logic [7:0] ADDR_PLD  = 8'h70;
  localparam logic [7:0] ADDR_STAT = 8'h74;

  localparam int Q_CMD = 0;
  localparam int Q_WP  = 1;
  localparam int Q_RD  = 2;
  localparam int NUM_Q = 3;

  typedef struct packed {
    logic cmdPush;
    logic cmdPop;
    logic wpPush;
    logic wpPop;
    logic rdPush;
    logic rdPop;
  } fifoStrobes_t;

  typedef struct packed {
    logic cmdEmpty;
    logic cmdFull;
    logic wpEmpty;
    logic wpFull;
    logic rdEmpty;
    logic rdFull;
  } fifoFlags_t;

  typedef enum logic {TX_IDLE, TX_PAYLOAD} txState_t;
endpackage

// File: rtl/cmdfe_fifo.sv
module cmdfe_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] head,
  output logic             full,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic [CW-1:0]    count;
  logic             doPush, doPop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full   = (count == CW'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign head   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= bump(wrPtr);
      if (doPop)  rdPtr <= bump(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R5: a push into a full queue without a pop leaves the occupancy alone
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rstN)
    (push && full && !pop) |=> $stable(count));

  // R1: flags follow a push one cycle later
  p_push_clears_empty_r1: assert property (@(posedge clk) disable iff (!rstN)
    (push && !pop) |=> !empty);
endmodule

// File: rtl/cmdfe_datapath.sv
module cmdfe_datapath
  import cmdfe_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoStrobes_t     strobes,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rxValid,
  input  logic [7:0]       rxByte,
  input  logic             rxLast,
  output logic [WIDTH-1:0] cmdHead,
  output logic [WIDTH-1:0] wpHead,
  output logic [WIDTH-1:0] rdHead,
  output fifoFlags_t       flags,
  output logic             packDone
);
  localparam int BPW = WIDTH / 8;
  localparam int IW  = (BPW > 1) ? $clog2(BPW) : 1;

  logic [NUM_Q-1:0] qPush, qPop, qFull, qEmpty;
  logic [WIDTH-1:0] qDin  [NUM_Q];
  logic [WIDTH-1:0] qHead [NUM_Q];

  logic [WIDTH-1:0] packAcc, packWord;
  logic [IW-1:0]    byteIdx;

  assign qPush[Q_CMD] = strobes.cmdPush;
  assign qPush[Q_WP]  = strobes.wpPush;
  assign qPush[Q_RD]  = strobes.rdPush;
  assign qPop[Q_CMD]  = strobes.cmdPop;
  assign qPop[Q_WP]   = strobes.wpPop;
  assign qPop[Q_RD]   = strobes.rdPop;
  assign qDin[Q_CMD]  = wrData;
  assign qDin[Q_WP]   = wrData;
  assign qDin[Q_RD]   = packWord;

  for (genvar q = 0; q < NUM_Q; q++) begin : g_queue
    cmdfe_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rstN  (rstN),
      .push  (qPush[q]),
      .pop   (qPop[q]),
      .din   (qDin[q]),
      .head  (qHead[q]),
      .full  (qFull[q]),
      .empty (qEmpty[q])
    );
  end

  assign cmdHead = qHead[Q_CMD];
  assign wpHead  = qHead[Q_WP];
  assign rdHead  = qHead[Q_RD];
  assign flags   = '{cmdEmpty: qEmpty[Q_CMD], cmdFull: qFull[Q_CMD],
                     wpEmpty:  qEmpty[Q_WP],  wpFull:  qFull[Q_WP],
                     rdEmpty:  qEmpty[Q_RD],  rdFull:  qFull[Q_RD]};

  // little-endian byte packer for returned read data
  assign packWord = packAcc | (WIDTH'(rxByte) << (8 * byteIdx));
  assign packDone = rxValid && (rxLast || byteIdx == IW'(BPW - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      packAcc <= '0;
      byteIdx <= '0;
    end else if (rxValid) begin
      if (packDone) begin
        packAcc <= '0;
        byteIdx <= '0;
      end else begin
        packAcc <= packWord;
        byteIdx <= byteIdx + 1'b1;
      end
    end
  end

  // R7: a word is never stored with bytes beyond those received
  p_pack_restart_r7: assert property (@(posedge clk) disable iff (!rstN)
    packDone |=> (byteIdx == '0));
endmodule

// File: rtl/cmdfe_control.sv
module cmdfe_control
  import cmdfe_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWr,
  input  logic             regRd,
  input  logic [7:0]       regAddr,
  input  logic [5:0]       wrType,
  output logic [WIDTH-1:0] regRdata,
  input  logic [WIDTH-1:0] cmdHead,
  input  logic [WIDTH-1:0] wpHead,
  input  logic [WIDTH-1:0] rdHead,
  input  fifoFlags_t       flags,
  input  logic             packDone,
  input  logic             rxValid,
  input  logic             rxLast,
  output fifoStrobes_t     strobes,
  output logic             pktValid,
  input  logic             pktReady,
  output logic [WIDTH-1:0] pktData,
  output logic             pktIsHeader
);
  localparam int WC_W  = 16;
  localparam int REM_W = WC_W - 1;

  txState_t         txState;
  logic [REM_W-1:0] remain;
  logic             busy, overflow, underflow;
  logic             wrHdr, wrPld, rdPld, fire, hdrIsRead, hdrLong;
  logic [WC_W:0]    wcRound;
  logic [REM_W-1:0] hdrWords;

  assign wrHdr = regWr && (regAddr == ADDR_HDR);
  assign wrPld = regWr && (regAddr == ADDR_PLD);
  assign rdPld = regRd && (regAddr == ADDR_PLD);

  assign hdrIsRead = !wrType[3] && (wrType[2:0] == 3'b100 || wrType[2:0] == 3'b110);
  assign hdrLong   = cmdHead[3];
  assign wcRound   = {1'b0, cmdHead[8 +: WC_W]} + (WC_W+1)'(3);
  assign hdrWords  = wcRound[WC_W:2];

  assign pktIsHeader = (txState == TX_IDLE);
  assign pktValid    = pktIsHeader ? !flags.cmdEmpty : !flags.wpEmpty;
  assign pktData     = pktIsHeader ? cmdHead : wpHead;
  assign fire        = pktValid && pktReady;

  always_comb begin
    strobes         = '0;
    strobes.cmdPush = wrHdr && !flags.cmdFull;
    strobes.wpPush  = wrPld && !flags.wpFull;
    strobes.rdPush  = packDone && !flags.rdFull;
    strobes.rdPop   = rdPld && !flags.rdEmpty;
    strobes.cmdPop  = fire && pktIsHeader;
    strobes.wpPop   = fire && !pktIsHeader;
  end

  always_comb begin
    regRdata = '0;
    if (regAddr == ADDR_PLD && !flags.rdEmpty) regRdata = rdHead;
    else if (regAddr == ADDR_STAT)
      regRdata = WIDTH'({underflow, overflow, busy, flags.rdFull, flags.rdEmpty,
                         flags.wpFull, flags.wpEmpty, flags.cmdFull, flags.cmdEmpty});
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txState   <= TX_IDLE;
      remain    <= '0;
      busy      <= 1'b0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      if (strobes.cmdPop && hdrLong && hdrWords != '0) begin
        txState <= TX_PAYLOAD;
        remain  <= hdrWords;
      end else if (strobes.wpPop) begin
        remain <= remain - 1'b1;
        if (remain == REM_W'(1)) txState <= TX_IDLE;
      end
      if (strobes.cmdPush && hdrIsRead) busy <= 1'b1;
      else if (rxValid && rxLast)       busy <= 1'b0;
      if ((wrHdr && flags.cmdFull) || (wrPld && flags.wpFull) || (packDone && flags.rdFull))
        overflow <= 1'b1;
      if (rdPld && flags.rdEmpty) underflow <= 1'b1;
    end
  end

  // R9: an offered word is held until taken
  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (pktValid && !pktReady) |=> (pktValid && $stable(pktData) && $stable(pktIsHeader)));

  // R3 / R2: a payload word only leaves while a header's count is outstanding
  p_payload_claimed_r3: assert property (@(posedge clk) disable iff (!rstN)
    (pktValid && !pktIsHeader) |-> (remain != '0));

  // R8: an accepted read-request header raises busy
  p_busy_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrHdr && !flags.cmdFull && hdrIsRead) |=> busy);

  // R6: popping an empty read queue leaves the sticky underflow flag set
  p_underflow_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rdPld && flags.rdEmpty) |=> underflow);
endmodule

// File: rtl/cmd_pkt_front.sv
module cmd_pkt_front
  import cmdfe_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWr,
  input  logic        regRd,
  input  logic [7:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  output logic        pktValid,
  input  logic        pktReady,
  output logic [31:0] pktData,
  output logic        pktIsHeader,
  input  logic        rxValid,
  input  logic [7:0]  rxByte,
  input  logic        rxLast
);
  localparam int WIDTH = 32;

  fifoStrobes_t     strobes;
  fifoFlags_t       flags;
  logic [WIDTH-1:0] cmdHead, wpHead, rdHead;
  logic             packDone;

  cmdfe_datapath #(.WIDTH(WIDTH), .DEPTH(FIFO_DEPTH)) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .wrData   (regWdata),
    .rxValid  (rxValid),
    .rxByte   (rxByte),
    .rxLast   (rxLast),
    .cmdHead  (cmdHead),
    .wpHead   (wpHead),
    .rdHead   (rdHead),
    .flags    (flags),
    .packDone (packDone)
  );

  cmdfe_control #(.WIDTH(WIDTH)) u_control (
    .clk         (clk),
    .rstN        (rstN),
    .regWr       (regWr),
    .regRd       (regRd),
    .regAddr     (regAddr),
    .wrType      (regWdata[5:0]),
    .regRdata    (regRdata),
    .cmdHead     (cmdHead),
    .wpHead      (wpHead),
    .rdHead      (rdHead),
    .flags       (flags),
    .packDone    (packDone),
    .rxValid     (rxValid),
    .rxLast      (rxLast),
    .strobes     (strobes),
    .pktValid    (pktValid),
    .pktReady    (pktReady),
    .pktData     (pktData),
    .pktIsHeader (pktIsHeader)
  );
endmodule

// File: tb/cmd_pkt_front_test.sv
module cmd_pkt_front_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0, regRd = 1'b0;
  logic [7:0]  regAddr = 8'h00;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        pktValid, pktIsHeader;
  logic        pktReady = 1'b1;
  logic [31:0] pktData;
  logic        rxValid = 1'b0, rxLast = 1'b0;
  logic [7:0]  rxByte = 8'h00;

  int vectors = 0, errors = 0, cycles = 0;
  int capCount = 0;
  logic [31:0] capData [64];
  logic        capHdr  [64];
  logic        expOvf = 1'b0, expUnf = 1'b0;

  always #2.5 clk = ~clk;

  cmd_pkt_front uut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .pktValid(pktValid),
    .pktReady(pktReady), .pktData(pktData), .pktIsHeader(pktIsHeader),
    .rxValid(rxValid), .rxByte(rxByte), .rxLast(rxLast)
  );

  always @(posedge clk) begin
    if (rstN && pktValid && pktReady && capCount < 64) begin
      capData[capCount] <= pktData;
      capHdr[capCount]  <= pktIsHeader;
      capCount          <= capCount + 1;
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 50000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors = vectors + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] stat(input logic cE, cF, wE, wF, rE, rF, bsy);
    return {23'b0, expUnf, expOvf, bsy, rF, rE, wF, wE, cF, cE};
  endfunction

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regRd = 1'b1; regAddr = a;
    #1 d = regRdata;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b, input logic last);
    @(negedge clk);
    rxValid = 1'b1; rxByte = b; rxLast = last;
    @(negedge clk);
    rxValid = 1'b0; rxLast = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic testReset();
    logic [31:0] s;
    regRead(8'h74, s);
    check("R10 reset status", s, 32'h15);
    check("R10 link idle", {31'b0, pktValid}, 32'h0);
  endtask

  task automatic testLongPacket();
    logic [31:0] s;
    int base;
    base = capCount;
    regWrite(8'h70, 32'h4433_2211);
    regWrite(8'h70, 32'h0000_6655);
    idle(8);
    check("R3 payload held without header", capCount - base, 0);
    regRead(8'h74, s);
    check("R4 payload staged status", s, stat(1, 0, 0, 0, 1, 0, 0));
    regWrite(8'h6C, 32'h0000_0629);
    idle(10);
    check("R2 long packet word count", capCount - base, 3);
    check("R2 header first", {capHdr[base], capData[base]}, {1'b1, 32'h0000_0629});
    check("R2 payload word 0", {capHdr[base+1], capData[base+1]}, {1'b0, 32'h4433_2211});
    check("R2 payload word 1", {capHdr[base+2], capData[base+2]}, {1'b0, 32'h0000_6655});
    regRead(8'h74, s);
    check("R1 both queues empty after packet", s, stat(1, 0, 1, 0, 1, 0, 0));
  endtask

  task automatic testShortPacket();
    int base;
    base = capCount;
    regWrite(8'h6C, 32'h0012_3405);
    idle(6);
    check("R2 short packet single word", capCount - base, 1);
    check("R2 short header data", capData[base], 32'h0012_3405);
  endtask

  task automatic testBackpressure();
    logic [31:0] s;
    int base;
    base = capCount;
    @(negedge clk) pktReady = 1'b0;
    @(negedge clk);
    regWr = 1'b1; regAddr = 8'h6C; regWdata = 32'h00AB_0015;
    @(negedge clk);
    regWr = 1'b0;
    regRead(8'h74, s);
    check("R1 header queue not empty", s, stat(0, 0, 1, 0, 1, 0, 0));
    check("R9 valid offered", {pktValid, pktIsHeader, pktData}, {2'b11, 32'h00AB_0015});
    idle(4);
    check("R9 valid held", {pktValid, pktIsHeader, pktData}, {2'b11, 32'h00AB_0015});
    @(negedge clk) pktReady = 1'b1;
    idle(4);
    check("R9 accepted after ready", capCount - base, 1);
  endtask

  task automatic testRead();
    logic [31:0] s, d;
    @(negedge clk);
    regWr = 1'b1; regAddr = 8'h6C; regWdata = 32'h0000_0014;
    @(negedge clk);
    regWr = 1'b0; regAddr = 8'h74;
    #1 s = regRdata;
    check("R8 busy after read header", s, stat(0, 0, 1, 0, 1, 0, 1));
    idle(4);
    sendByte(8'h11, 1'b0);
    sendByte(8'h22, 1'b0);
    sendByte(8'h33, 1'b0);
    sendByte(8'h44, 1'b0);
    regRead(8'h74, s);
    check("R8 busy until last byte", s, stat(1, 0, 1, 0, 0, 0, 1));
    sendByte(8'h55, 1'b1);
    regRead(8'h74, s);
    check("R8 busy cleared", s, stat(1, 0, 1, 0, 0, 0, 0));
    regRead(8'h70, d);
    check("R7 little-endian word", d, 32'h4433_2211);
    regRead(8'h70, d);
    check("R7 zero-padded partial", d, 32'h0000_0055);
    regRead(8'h70, d);
    check("R6 empty read returns zero", d, 32'h0);
    expUnf = 1'b1;
    regRead(8'h74, s);
    check("R6 underflow sticky", s, stat(1, 0, 1, 0, 1, 0, 0));
  endtask

  task automatic testCmdOverflow();
    logic [31:0] s;
    int base;
    base = capCount;
    @(negedge clk) pktReady = 1'b0;
    for (int i = 0; i < 17; i++) regWrite(8'h6C, {16'h0, 8'(i), 8'h05});
    expOvf = 1'b1;
    regRead(8'h74, s);
    check("R5 header queue full and overflow", s, stat(0, 1, 1, 0, 1, 0, 0));
    @(negedge clk) pktReady = 1'b1;
    idle(24);
    check("R5 seventeenth header dropped", capCount - base, 16);
    check("R5 last kept header", capData[base+15], 32'h0000_0F05);
  endtask

  task automatic testReadOverflow();
    logic [31:0] s, d;
    for (int k = 0; k < 17; k++)
      for (int j = 0; j < 4; j++)
        sendByte(8'(4*k + j), (k == 16 && j == 3));
    regRead(8'h74, s);
    check("R5 read queue full", s, stat(1, 0, 1, 0, 0, 1, 0));
    for (int k = 0; k < 16; k++) begin
      regRead(8'h70, d);
      check("R6 read queue pop order", d,
            {8'(4*k + 3), 8'(4*k + 2), 8'(4*k + 1), 8'(4*k)});
    end
    regRead(8'h74, s);
    check("R5 read queue drained, extra word dropped", s, stat(1, 0, 1, 0, 1, 0, 0));
  endtask

  initial begin
    idle(3);
    @(negedge clk) rstN = 1'b1;
    testReset();
    testLongPacket();
    testShortPacket();
    testBackpressure();
    testRead();
    testCmdOverflow();
    testReadOverflow();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule